// File: doc/BRIEF.md
# DDR Serial ADC Lane Deserializer

This block turns one serial converter data lane back into parallel 12-bit samples. The lane and the frame clock are captured outside the block by double-data-rate input cells. Each cycle of the bit clock therefore hands the core two data bits and two frame bits. The bit clock runs at six times the sample rate, so one sample takes six core cycles. The serial stream carries the least significant bit first.

Word boundaries come from the frame clock, which is treated as an extra data lane. A rising frame level, seen on the rising-edge frame bit, marks the first pair of a new word and produces a one-cycle load. That load copies the six pairs received before it from a shift chain into the output register. The shift chain is longer than a sample by `ALIGN_PAD` bit pairs. This covers the registers that the frame edge detector adds, so the same bits are captured whatever the padding.

The output code is either the converter's offset binary or two's complement, in which the most significant bit is inverted. An alignment flag comes with each sample. It marks frames whose spacing was not six cycles, and frames whose edge fell between the two captures of a cycle.

Top module: `ddr_adc_deser`

## Requirements
- R1: While `rst_n` is low, and until the first load after it rises, `sample` is 0x000 and `sample_valid` and `align_err` are 0. The shift chain starts as all zeros. The frame level is taken as low in the cycle before reset release.
- R2: `din_pair[0]` is the earlier bit (rising edge) and `din_pair[1]` the later bit (falling edge). In a word, the pair of its k-th cycle (k = 0..5) fills sample bits 2k and 2k+1, so the first bit received lands in bit 0.
- R3: A frame rise is counted at capture edge r when `frame_pair[0]` is 1 there and was 0 at edge r-1. The word built from the pairs of edges r-6 to r-1 is then loaded at edge r+`ALIGN_PAD`. `sample_valid` is 1 for the clock period after that edge.
- R4: `sample_valid` is 0 in every period that does not follow a load edge, so it never stays high for two periods in a row.
- R5: With `twos_mode` = 0 at the load edge, `sample` equals the assembled offset-binary word: 0x000 is negative full scale, 0x800 is zero and 0xFFF is positive full scale.
- R6: With `twos_mode` = 1 at the load edge, `sample` is the word with bit 11 inverted: 0x800 gives 0x000, 0xFFF gives 0x7FF and 0x000 gives 0x800.
- R7: `sample` keeps its value in every period in which `sample_valid` is 0.
- R8: `align_err` is 1 with a sample when its frame rise came a number of capture edges other than six after the previous frame rise. The first rise after reset never raises it on spacing grounds.
- R9: `align_err` is 1 with a sample when, since the previous load edge (or reset), some edge captured `frame_pair` = 2'b10 (falling-edge bit high, rising-edge bit low), at or after that previous load edge and before the current one.
- R10: `align_err` is 0 in every period in which `sample_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, six cycles per sample |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| twos_mode | input | 1 | 1 selects two's complement output, 0 selects offset binary |
| din_pair | input | 2 | Captured data bits: [0] rising edge, [1] falling edge |
| frame_pair | input | 2 | Captured frame clock bits: [0] rising edge, [1] falling edge |
| sample | output | 12 | Reassembled sample |
| sample_valid | output | 1 | One-cycle strobe marking a new sample |
| align_err | output | 1 | Frame spacing or half-cycle frame edge fault for this sample |

## Verification
Each result is due `ALIGN_PAD` capture edges after the edge that sees the frame rise, and is visible in the period that follows. The bench records every driven pair and frame bit by edge index. When it drives a frame rise it books the expected word, spacing fault and edge index for that later edge. It resolves the output code and any half-cycle frame fault only when it drives the load edge itself, because the mode and the fault both take effect at that edge. It compares outputs on the falling clock edge. This is after the booked edge and before the next one, so every period is checked either as a load period or as a hold period.

// File: rtl/ddr_deser_pkg.sv
package ddr_deser_pkg;

  localparam int DEF_SAMPLE_W = 12;
  localparam int DEF_ALIGN_PAD = 1;

  typedef enum logic {
    CODE_OFFSET = 1'b0,
    CODE_TWOS   = 1'b1
  } code_mode_e;

endpackage

// File: rtl/deser_shift_chain.sv
module deser_shift_chain #(
  parameter int SAMPLE_W  = 12,
  parameter int ALIGN_PAD = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          din_pair,
  output logic [SAMPLE_W-1:0] word
);

  localparam int CHAIN_W = SAMPLE_W + 2 * ALIGN_PAD;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;

  // newest pair enters at the top; oldest pair drifts toward bit 0
  always_comb begin
    chain_d = {din_pair, chain_q[CHAIN_W-1:2]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign word = chain_q[SAMPLE_W-1:0];

endmodule

// File: rtl/deser_frame_detect.sv
module deser_frame_detect #(
  parameter int SAMPLE_W  = 12,
  parameter int ALIGN_PAD = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] frame_pair,
  output logic       load,
  output logic       frame_err
);

  localparam int FRAME_CYC = SAMPLE_W / 2;
  localparam int CNT_W     = $clog2(2 * FRAME_CYC + 2);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_GOOD = CNT_W'(FRAME_CYC - 1);

  // frame level delay line: tap ALIGN_PAD is "now", tap ALIGN_PAD+1 is "before"
  logic [ALIGN_PAD:0]   fdl_q, fdl_d;
  logic [ALIGN_PAD+1:0] ftap;
  logic                 lvl_now, lvl_before, rise;
  logic                 half_edge;

  logic [CNT_W-1:0] gap_q, gap_d;
  logic             seen_q, seen_d;
  logic             pend_q, pend_d;
  logic             gap_en;
  logic             spacing_bad;

  assign ftap       = {fdl_q, frame_pair[0]};
  assign lvl_now    = ftap[ALIGN_PAD];
  assign lvl_before = ftap[ALIGN_PAD+1];
  assign rise       = lvl_now & ~lvl_before;
  assign half_edge  = frame_pair[1] & ~frame_pair[0];

  always_comb begin
    fdl_d       = ftap[ALIGN_PAD:0];
    gap_en      = rise | (gap_q != CNT_MAX);
    gap_d       = rise ? '0 : gap_q + 1'b1;
    seen_d      = seen_q | rise;
    pend_d      = half_edge | (pend_q & ~rise);
    spacing_bad = seen_q & (gap_q != CNT_GOOD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fdl_q  <= '0;
      gap_q  <= '0;
      seen_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      fdl_q  <= fdl_d;
      if (gap_en) begin
        gap_q <= gap_d;
      end
      seen_q <= seen_d;
      pend_q <= pend_d;
    end
  end

  assign load      = rise;
  assign frame_err = rise & (pend_q | spacing_bad);

  AST_LOAD_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !load); // R4

  AST_ERR_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> load); // R10

endmodule

// File: rtl/deser_out_reg.sv
module deser_out_reg
  import ddr_deser_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                frame_err,
  input  logic [SAMPLE_W-1:0] word,
  input  code_mode_e          mode,
  output logic [SAMPLE_W-1:0] sample,
  output logic                sample_valid,
  output logic                align_err
);

  localparam int MSB = SAMPLE_W - 1;

  logic [SAMPLE_W-1:0] sample_q, sample_d;
  logic                valid_q, valid_d;
  logic                err_q, err_d;

  always_comb begin
    sample_d = {word[MSB] ^ (mode == CODE_TWOS), word[MSB-1:0]};
    valid_d  = load;
    err_d    = frame_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_q <= '0;
      valid_q  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (load) begin
        sample_q <= sample_d;
      end
      valid_q <= valid_d;
      err_q   <= err_d;
    end
  end

  assign sample       = sample_q;
  assign sample_valid = valid_q;
  assign align_err    = err_q;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |-> $stable(sample)); // R7

  AST_ERR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> sample_valid); // R10

endmodule

// File: rtl/ddr_adc_deser.sv
module ddr_adc_deser
  import ddr_deser_pkg::*;
#(
  parameter int SAMPLE_W  = DEF_SAMPLE_W,
  parameter int ALIGN_PAD = DEF_ALIGN_PAD
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                twos_mode,
  input  logic [1:0]          din_pair,
  input  logic [1:0]          frame_pair,
  output logic [SAMPLE_W-1:0] sample,
  output logic                sample_valid,
  output logic                align_err
);

  logic [SAMPLE_W-1:0] word;
  logic                load;
  logic                frame_err;

  deser_shift_chain #(
    .SAMPLE_W (SAMPLE_W),
    .ALIGN_PAD(ALIGN_PAD)
  ) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .din_pair(din_pair),
    .word    (word)
  );

  deser_frame_detect #(
    .SAMPLE_W (SAMPLE_W),
    .ALIGN_PAD(ALIGN_PAD)
  ) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_pair(frame_pair),
    .load      (load),
    .frame_err (frame_err)
  );

  deser_out_reg #(
    .SAMPLE_W(SAMPLE_W)
  ) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (load),
    .frame_err   (frame_err),
    .word        (word),
    .mode        (code_mode_e'(twos_mode)),
    .sample      (sample),
    .sample_valid(sample_valid),
    .align_err   (align_err)
  );

  AST_VALID_FOLLOWS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> sample_valid); // R3

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid); // R4

endmodule

// File: tb/sim_ddr_adc_deser.sv
module sim_ddr_adc_deser;

  localparam int CLK_PERIOD = 10;
  localparam int SW         = 12;
  localparam int PAD        = 1;
  localparam int NCYC       = 4096;

  logic          clk;
  logic          rst_n;
  logic          twos_mode;
  logic [1:0]    din_pair;
  logic [1:0]    frame_pair;
  logic [SW-1:0] sample;
  logic          sample_valid;
  logic          align_err;

  ddr_adc_deser #(.SAMPLE_W(SW), .ALIGN_PAD(PAD)) u0 (
    .clk(clk), .rst_n(rst_n), .twos_mode(twos_mode),
    .din_pair(din_pair), .frame_pair(frame_pair),
    .sample(sample), .sample_valid(sample_valid), .align_err(align_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [1:0]    hist  [NCYC];
  bit            ld_at [NCYC];
  logic [SW-1:0] raw_at[NCYC];
  bit            sp_at [NCYC];
  bit            mid_at[NCYC];
  bit            md_at [NCYC];
  logic [SW-1:0] exp_s [NCYC];
  bit            exp_e [NCYC];

  int            cyc;
  bit            prev_f0;
  int            last_rise;
  bit            mid_acc;
  logic [SW-1:0] held;
  string         phase_tag;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s at edge %0d: actual=0x%0h expected=0x%0h",
               tag, what, cyc - 1, act, exp);
    end
  endtask

  // reference model for one capture edge, then pins
  task automatic apply(input logic [1:0] d, input logic [1:0] f, input bit m);
    int c;
    c = cyc;
    hist[c] = d;
    if (f[0] && !prev_f0) begin
      logic [SW-1:0] raw;
      raw = '0;
      for (int j = 0; j < SW / 2; j++) begin
        int idx;
        logic [1:0] pr;
        idx = c - SW / 2 + j;
        pr  = (idx >= 0) ? hist[idx] : 2'b00;
        raw[2*j]   = pr[0];
        raw[2*j+1] = pr[1];
      end
      ld_at[c + PAD]  = 1'b1;
      raw_at[c + PAD] = raw;
      sp_at[c + PAD]  = (last_rise >= 0) && (c - last_rise != SW / 2);
      last_rise = c;
    end
    prev_f0 = f[0];
    if (ld_at[c]) begin
      exp_s[c]  = {raw_at[c][SW-1] ^ m, raw_at[c][SW-2:0]};
      md_at[c]  = m;
      mid_at[c] = mid_acc;
      exp_e[c]  = sp_at[c] | mid_acc;
      mid_acc   = 1'b0;
    end
    if (f[1] && !f[0]) mid_acc = 1'b1;
    din_pair   = d;
    frame_pair = f;
    twos_mode  = m;
    cyc++;
  endtask

  task automatic check_edge();
    int e;
    string st, et;
    e = cyc - 1;
    if (ld_at[e]) begin
      chk(sample_valid == 1'b1, "R3", "valid after load", int'(sample_valid), 1);
      st = (phase_tag != "") ? phase_tag : (md_at[e] ? "R6" : "R5");
      chk(sample == exp_s[e], st, "sample", int'(sample), int'(exp_s[e]));
      et = (exp_e[e] && mid_at[e] && !sp_at[e]) ? "R9" : "R8";
      chk(align_err == exp_e[e], et, "align_err", int'(align_err), int'(exp_e[e]));
      held = exp_s[e];
    end else begin
      chk(sample_valid == 1'b0, "R4", "valid idle", int'(sample_valid), 0);
      chk(align_err == 1'b0, "R10", "err idle", int'(align_err), 0);
      chk(sample == held, "R7", "hold", int'(sample), int'(held));
    end
  endtask

  task automatic drive(input logic [1:0] d, input logic [1:0] f, input bit m);
    @(negedge clk);
    check_edge();
    apply(d, f, m);
  endtask

  // one regular frame carrying word w, LSB first
  task automatic send_word(input logic [SW-1:0] w, input bit m);
    for (int j = 0; j < SW / 2; j++)
      drive({w[2*j+1], w[2*j]}, (j < SW / 4) ? 2'b11 : 2'b00, m);
  endtask

  task automatic rand_frame();
    int kind, len;
    bit m;
    kind = $urandom_range(0, 9);
    m    = 1'($urandom_range(0, 1));
    len  = (kind == 6) ? 5 : (kind == 7) ? 7 : (kind == 9) ? 9 : 6;
    for (int j = 0; j < len; j++) begin
      logic [1:0] f;
      if (kind == 9)                f = 2'b00;
      else if (kind == 8 && j == 0) f = 2'b10;
      else                          f = (j < (len + 1) / 2) ? 2'b11 : 2'b00;
      drive(2'($urandom_range(0, 3)), f, m);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NCYC; i++) begin
      ld_at[i] = 1'b0; sp_at[i] = 1'b0; mid_at[i] = 1'b0; md_at[i] = 1'b0;
      hist[i] = 2'b00; raw_at[i] = '0; exp_s[i] = '0; exp_e[i] = 1'b0;
    end
    cyc = 0; prev_f0 = 1'b0; last_rise = -1; mid_acc = 1'b0;
    held = '0; phase_tag = "";
    rst_n = 1'b0; twos_mode = 1'b0; din_pair = 2'b00; frame_pair = 2'b00;
    repeat (3) @(negedge clk);
    // R1: outputs while reset is held
    chk(sample == '0, "R1", "reset sample", int'(sample), 0);
    chk(sample_valid == 1'b0, "R1", "reset valid", int'(sample_valid), 0);
    chk(align_err == 1'b0, "R1", "reset err", int'(align_err), 0);
    rst_n = 1'b1;
    apply(2'b00, 2'b00, 1'b0);
    drive(2'b00, 2'b00, 1'b0);

    // R2: bit order, offset binary pass-through
    phase_tag = "R2";
    send_word(12'h001, 1'b0);
    send_word(12'hA5C, 1'b0);
    send_word(12'h800, 1'b0);
    send_word(12'h3C6, 1'b0);
    // R6: two's complement corners
    phase_tag = "R6";
    send_word(12'h800, 1'b1);
    send_word(12'hFFF, 1'b1);
    send_word(12'h000, 1'b1);
    send_word(12'h555, 1'b1);
    // R5: offset binary full scale
    phase_tag = "R5";
    send_word(12'hFFF, 1'b0);
    send_word(12'h000, 1'b0);
    send_word(12'h800, 1'b0);
    phase_tag = "";

    // random frames with short, long, gap and half-cycle edges (R8, R9)
    while (cyc < NCYC - 40) rand_frame();
    repeat (4) drive(2'b00, 2'b00, 1'b0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule